// File: doc/BRIEF.md
# Chained Hash Table Insert Engine

This engine adds a key/value pair to one bucket of a hash table that resolves collisions with linked lists. An upstream stage hashes the key and hands over the command with the bucket index and that bucket's head entry, a cell pointer plus a valid flag. The engine then follows the bucket's list through a data RAM whose reads return after a fixed latency. It either updates the value of a cell that already holds the key or adds a new cell at the end of the list. A new cell's address comes from an external free-cell allocator.

Commands enter on a valid/ready port. `cmd_ready` is high only while the engine is idle, so one insert is in flight at a time. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The outcome leaves on a second valid/ready port. `res_valid` stays high, with code and key held steady, until a clock edge sees `res_ready` high. No further command is accepted before then. The allocator must keep `alloc_addr` steady while `alloc_avail` is high until it sees `alloc_take`. Head-table and RAM writes take effect on the clock edge where their enables are high.

Top module: `chain_insert_engine`

## Requirements
- R1: After reset `cmd_ready` is 1 and `res_valid`, `ram_wr_en`, `head_wr_en` and `alloc_take` are 0. `cmd_ready` and `res_valid` are never high in the same cycle.
- R2: For a bucket whose head flag is 0, with a free cell available, the engine writes the head table (pointer = allocated address, flag = 1) in one cycle. In the following cycle it writes the data cell at that address with its next-valid flag 0. The result code is 0 (added).
- R3: For a bucket with a valid head, the engine reads the head cell and then each cell named by a valid next pointer. It uses read data that arrives RD_LAT cycles after the read request, and it keeps at most one read outstanding.
- R4: If a cell on the list holds the command key, only that cell is rewritten: new value, same key, same next pointer and flag. The result code is 1 (same key), and no cell is allocated.
- R5: At the end of a list the engine first writes the new cell (next-valid 0). In the next cycle it rewrites the old tail cell with next pointer = new address and flag 1. No RAM write ever carries a valid next pointer equal to its own address.
- R6: If the key is absent and the allocator has no free cell, the result code is 2 (table full), and the engine makes no head write, no RAM write and no allocation. A same-key update still succeeds when the table is full.
- R7: `alloc_take` pulses for exactly one cycle per new cell, in the cycle of the new cell's write, and never otherwise.
- R8: While `res_valid` is 1 and `res_ready` is 0, the result code and key stay unchanged and `cmd_valid` is ignored.
- R9: Any 2^AW distinct keys fit, whatever their bucket spread, including all of them on one list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, takes the command |
| cmd_key | input | KW | Key to insert |
| cmd_value | input | VW | Value to store |
| cmd_bucket | input | BW | Bucket index from the hash stage |
| cmd_head_ptr | input | AW | Bucket head cell address |
| cmd_head_vld | input | 1 | Bucket head is valid |
| alloc_avail | input | 1 | A free cell exists |
| alloc_addr | input | AW | Free cell address, steady until taken |
| alloc_take | output | 1 | Consumes `alloc_addr` |
| head_wr_en | output | 1 | Head-table write strobe |
| head_wr_bucket | output | BW | Head-table write address |
| head_wr_ptr | output | AW | New head pointer |
| head_wr_vld | output | 1 | New head valid flag |
| ram_rd_en | output | 1 | Data RAM read request |
| ram_rd_addr | output | AW | Data RAM read address |
| ram_rd_key | input | KW | Read cell key (RD_LAT cycles after request) |
| ram_rd_value | input | VW | Read cell value |
| ram_rd_next | input | AW | Read cell next pointer |
| ram_rd_nvld | input | 1 | Read cell next-valid flag |
| ram_wr_en | output | 1 | Data RAM write strobe |
| ram_wr_addr | output | AW | Data RAM write address |
| ram_wr_key | output | KW | Written key |
| ram_wr_value | output | VW | Written value |
| ram_wr_next | output | AW | Written next pointer |
| ram_wr_nvld | output | 1 | Written next-valid flag |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_code | output | 2 | 0 added, 1 same key, 2 table full |
| res_key | output | KW | Key the result belongs to |

## Verification
Two functions can meet in one cycle: a result held under back-pressure and the arrival of the next command. The bench holds `res_ready` low for several cycles and drives `cmd_valid` with a different key during that time. Each cycle it checks that `cmd_ready` stays 0, that the result code is steady, and that no write or allocation appears. The other pair is the new-cell write and the allocator take, which must share a cycle. The bench judges this through its allocator and RAM models, compares every list against a queue-based model, and flags any write that would link a cell to itself.

// File: rtl/ins_pkg.sv
package ins_pkg;
  typedef enum logic [1:0] {
    RES_ADDED = 2'd0,
    RES_SAME  = 2'd1,
    RES_FULL  = 2'd2
  } ins_res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HEAD_WR,
    ST_NEW_WR,
    ST_RD,
    ST_WAIT,
    ST_CHECK,
    ST_UPD_WR,
    ST_LINK_WR,
    ST_RESP
  } ins_st_e;
endpackage

// File: rtl/ins_rd_track.sv
module ins_rd_track #(
  parameter int LAT = 2,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          ret,
  output logic [AW-1:0] ret_addr
);
  logic [LAT-1:0] vpipe;
  logic [AW-1:0]  apipe [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) vpipe[g] <= 1'b0;
        else        vpipe[g] <= issue;
        apipe[g] <= issue_addr;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) vpipe[g] <= 1'b0;
        else        vpipe[g] <= vpipe[g-1];
        apipe[g] <= apipe[g-1];
      end
    end
  end

  assign ret      = vpipe[LAT-1];
  assign ret_addr = apipe[LAT-1];

  // R3
  rd_one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (vpipe == '0));
endmodule

// File: rtl/ins_cell_hold.sv
module ins_cell_hold #(
  parameter int KW = 16,
  parameter int VW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [KW-1:0] in_key,
  input  logic [VW-1:0] in_val,
  input  logic [AW-1:0] in_next,
  input  logic          in_nvld,
  output logic [AW-1:0] h_addr,
  output logic [KW-1:0] h_key,
  output logic [VW-1:0] h_val,
  output logic [AW-1:0] h_next,
  output logic          h_nvld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_addr <= '0;
      h_key  <= '0;
      h_val  <= '0;
      h_next <= '0;
      h_nvld <= 1'b0;
    end else if (load) begin
      h_addr <= in_addr;
      h_key  <= in_key;
      h_val  <= in_val;
      h_next <= in_next;
      h_nvld <= in_nvld;
    end
  end
endmodule

// File: rtl/chain_insert_engine.sv
module chain_insert_engine
  import ins_pkg::*;
#(
  parameter int KW     = 16,
  parameter int VW     = 8,
  parameter int BW     = 2,
  parameter int AW     = 3,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [KW-1:0] cmd_key,
  input  logic [VW-1:0] cmd_value,
  input  logic [BW-1:0] cmd_bucket,
  input  logic [AW-1:0] cmd_head_ptr,
  input  logic          cmd_head_vld,
  input  logic          alloc_avail,
  input  logic [AW-1:0] alloc_addr,
  output logic          alloc_take,
  output logic          head_wr_en,
  output logic [BW-1:0] head_wr_bucket,
  output logic [AW-1:0] head_wr_ptr,
  output logic          head_wr_vld,
  output logic          ram_rd_en,
  output logic [AW-1:0] ram_rd_addr,
  input  logic [KW-1:0] ram_rd_key,
  input  logic [VW-1:0] ram_rd_value,
  input  logic [AW-1:0] ram_rd_next,
  input  logic          ram_rd_nvld,
  output logic          ram_wr_en,
  output logic [AW-1:0] ram_wr_addr,
  output logic [KW-1:0] ram_wr_key,
  output logic [VW-1:0] ram_wr_value,
  output logic [AW-1:0] ram_wr_next,
  output logic          ram_wr_nvld,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [1:0]    res_code,
  output logic [KW-1:0] res_key
);
  ins_st_e       st;
  ins_res_e      code_r;
  logic [KW-1:0] k_r;
  logic [VW-1:0] v_r;
  logic [BW-1:0] bkt_r;
  logic [AW-1:0] walk_ptr;
  logic [AW-1:0] new_ptr;
  logic          link_f;

  logic          ret;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] h_addr;
  logic [KW-1:0] h_key;
  logic [VW-1:0] h_val;
  logic [AW-1:0] h_next;
  logic          h_nvld;

  ins_rd_track #(.LAT(RD_LAT), .AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .issue(ram_rd_en), .issue_addr(ram_rd_addr),
    .ret(ret), .ret_addr(ret_addr)
  );

  // The tail cell's address and contents stay latched until the link write.
  ins_cell_hold #(.KW(KW), .VW(VW), .AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(ret),
    .in_addr(ret_addr), .in_key(ram_rd_key), .in_val(ram_rd_value),
    .in_next(ram_rd_next), .in_nvld(ram_rd_nvld),
    .h_addr(h_addr), .h_key(h_key), .h_val(h_val),
    .h_next(h_next), .h_nvld(h_nvld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      code_r   <= RES_ADDED;
      k_r      <= '0;
      v_r      <= '0;
      bkt_r    <= '0;
      walk_ptr <= '0;
      new_ptr  <= '0;
      link_f   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          k_r    <= cmd_key;
          v_r    <= cmd_value;
          bkt_r  <= cmd_bucket;
          link_f <= 1'b0;
          if (cmd_head_vld) begin
            walk_ptr <= cmd_head_ptr;
            st       <= ST_RD;
          end else if (alloc_avail) begin
            new_ptr <= alloc_addr;
            st      <= ST_HEAD_WR;
          end else begin
            code_r <= RES_FULL;
            st     <= ST_RESP;
          end
        end
        ST_HEAD_WR: st <= ST_NEW_WR;
        ST_NEW_WR: begin
          if (link_f) st <= ST_LINK_WR;
          else begin
            code_r <= RES_ADDED;
            st     <= ST_RESP;
          end
        end
        ST_RD:   st <= ST_WAIT;
        ST_WAIT: if (ret) st <= ST_CHECK;
        ST_CHECK: begin
          if (h_key == k_r) st <= ST_UPD_WR;
          else if (h_nvld) begin
            walk_ptr <= h_next;
            st       <= ST_RD;
          end else if (alloc_avail) begin
            new_ptr <= alloc_addr;
            link_f  <= 1'b1;
            st      <= ST_NEW_WR;
          end else begin
            code_r <= RES_FULL;
            st     <= ST_RESP;
          end
        end
        ST_UPD_WR: begin
          code_r <= RES_SAME;
          st     <= ST_RESP;
        end
        ST_LINK_WR: begin
          code_r <= RES_ADDED;
          st     <= ST_RESP;
        end
        ST_RESP: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready      = (st == ST_IDLE);
  assign res_valid      = (st == ST_RESP);
  assign res_code       = code_r;
  assign res_key        = k_r;
  assign head_wr_en     = (st == ST_HEAD_WR);
  assign head_wr_bucket = bkt_r;
  assign head_wr_ptr    = new_ptr;
  assign head_wr_vld    = 1'b1;
  assign ram_rd_en      = (st == ST_RD);
  assign ram_rd_addr    = walk_ptr;
  assign alloc_take     = (st == ST_NEW_WR);

  always_comb begin
    ram_wr_en    = 1'b0;
    ram_wr_addr  = new_ptr;
    ram_wr_key   = k_r;
    ram_wr_value = v_r;
    ram_wr_next  = '0;
    ram_wr_nvld  = 1'b0;
    unique case (st)
      ST_NEW_WR: ram_wr_en = 1'b1;
      ST_UPD_WR: begin
        ram_wr_en   = 1'b1;
        ram_wr_addr = h_addr;
        ram_wr_key  = h_key;
        ram_wr_next = h_next;
        ram_wr_nvld = h_nvld;
      end
      ST_LINK_WR: begin
        ram_wr_en    = 1'b1;
        ram_wr_addr  = h_addr;
        ram_wr_key   = h_key;
        ram_wr_value = h_val;
        ram_wr_next  = new_ptr;
        ram_wr_nvld  = 1'b1;
      end
      default: ;
    endcase
  end

  // R1
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && res_valid));
  // R2
  head_then_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr_en |=> ram_wr_en && !ram_wr_nvld && (ram_wr_addr == $past(head_wr_ptr)));
  // R5
  no_self_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en && ram_wr_nvld) |-> (ram_wr_next != ram_wr_addr));
  // R5
  link_after_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en && ram_wr_nvld && ram_wr_next == $past(ram_wr_addr) && $past(alloc_take))
      |-> $past(ram_wr_en && !ram_wr_nvld));
  // R7
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |=> !alloc_take);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_code) && $stable(res_key));
endmodule

// File: tb/tb_chain_insert_engine.sv
module tb_chain_insert_engine;
  localparam int KW = 16, VW = 8, BW = 2, AW = 3, LAT = 2;
  localparam int N = 1 << AW;
  localparam int NB = 1 << BW;
  localparam int WW = KW + VW + AW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [KW-1:0] cmd_key = '0;
  logic [VW-1:0] cmd_value = '0;
  logic [BW-1:0] cmd_bucket = '0;
  logic [AW-1:0] cmd_head_ptr = '0;
  logic cmd_head_vld = 1'b0;
  logic alloc_avail, alloc_take;
  logic [AW-1:0] alloc_addr;
  logic head_wr_en, head_wr_vld;
  logic [BW-1:0] head_wr_bucket;
  logic [AW-1:0] head_wr_ptr;
  logic ram_rd_en, ram_rd_nvld, ram_wr_en, ram_wr_nvld;
  logic [AW-1:0] ram_rd_addr, ram_rd_next, ram_wr_addr, ram_wr_next;
  logic [KW-1:0] ram_rd_key, ram_wr_key, res_key;
  logic [VW-1:0] ram_rd_value, ram_wr_value;
  logic res_valid, res_ready = 1'b1;
  logic [1:0] res_code;

  always #5 clk = ~clk;

  chain_insert_engine #(.KW(KW), .VW(VW), .BW(BW), .AW(AW), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_key(cmd_key), .cmd_value(cmd_value), .cmd_bucket(cmd_bucket),
    .cmd_head_ptr(cmd_head_ptr), .cmd_head_vld(cmd_head_vld),
    .alloc_avail(alloc_avail), .alloc_addr(alloc_addr), .alloc_take(alloc_take),
    .head_wr_en(head_wr_en), .head_wr_bucket(head_wr_bucket),
    .head_wr_ptr(head_wr_ptr), .head_wr_vld(head_wr_vld),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_key(ram_rd_key), .ram_rd_value(ram_rd_value),
    .ram_rd_next(ram_rd_next), .ram_rd_nvld(ram_rd_nvld),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_key(ram_wr_key),
    .ram_wr_value(ram_wr_value), .ram_wr_next(ram_wr_next), .ram_wr_nvld(ram_wr_nvld),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code), .res_key(res_key)
  );

  // Bench-owned memories: data RAM, head table, free map
  logic [KW-1:0] m_key [N];
  logic [VW-1:0] m_val [N];
  logic [AW-1:0] m_next [N];
  logic          m_nv [N];
  logic          free_c [N];
  logic [AW-1:0] hptr [NB];
  logic          hv [NB];
  logic [WW-1:0] p1 = '0, p2 = '0, p3 = '0;

  assign {ram_rd_key, ram_rd_value, ram_rd_next, ram_rd_nvld} = p3;

  always_comb begin
    alloc_avail = 1'b0;
    alloc_addr  = '0;
    for (int i = N - 1; i >= 0; i--)
      if (free_c[i]) begin
        alloc_avail = 1'b1;
        alloc_addr  = AW'(i);
      end
  end

  int nchk = 0, nfail = 0, cyc = 0;
  int wn, hw_cnt, tk, hw_cyc, rw_cyc;
  int wl_addr [4], wl_next [4], wl_nv [4];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      free_c[i] = 1'b1; m_key[i] = '0; m_val[i] = '0; m_next[i] = '0; m_nv[i] = 1'b0;
    end
    for (int b = 0; b < NB; b++) begin hptr[b] = '0; hv[b] = 1'b0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  // Models of the RAM read pipe, writes and allocator, acting every cycle
  always @(negedge clk) if (rst_n) begin
    p3 = p2; p2 = p1;
    p1 = ram_rd_en ? {m_key[ram_rd_addr], m_val[ram_rd_addr], m_next[ram_rd_addr], m_nv[ram_rd_addr]} : '0;
    if (cmd_ready && res_valid) chk(0, "R1 ready/result overlap", 1, 0);
    if (head_wr_en) begin
      hptr[head_wr_bucket] = head_wr_ptr; hv[head_wr_bucket] = head_wr_vld;
      hw_cnt++; hw_cyc = cyc;
    end
    if (ram_wr_en) begin
      if (ram_wr_nvld && ram_wr_next == ram_wr_addr)
        chk(0, "R5 self link", int'(ram_wr_next), -1);
      m_key[ram_wr_addr] = ram_wr_key; m_val[ram_wr_addr] = ram_wr_value;
      m_next[ram_wr_addr] = ram_wr_next; m_nv[ram_wr_addr] = ram_wr_nvld;
      if (wn == 0) rw_cyc = cyc;
      if (wn < 4) begin
        wl_addr[wn] = int'(ram_wr_addr); wl_next[wn] = int'(ram_wr_next); wl_nv[wn] = int'(ram_wr_nvld);
      end
      wn++;
    end
    if (alloc_take) begin
      free_c[alloc_addr] = 1'b0; tk++;
    end
  end

  // Reference model: ordered key list per bucket plus a value map
  int mk [NB][$];
  int mval [int];
  int ncnt = 0;
  int n_added = 0;

  task automatic run_cmd(input int key, input int val, input int hold);
    int b, ecode, p;
    bit found, was_empty;
    b = (key >> (KW - BW)) & (NB - 1);
    found = 0;
    foreach (mk[b][i]) if (mk[b][i] == key) found = 1;
    was_empty = (mk[b].size() == 0);
    ecode = found ? 1 : (ncnt == N ? 2 : 0);
    wn = 0; hw_cnt = 0; tk = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_key = KW'(key); cmd_value = VW'(val);
    cmd_bucket = BW'(b); cmd_head_ptr = hptr[b]; cmd_head_vld = hv[b];
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    res_ready = (hold == 0);
    while (!res_valid) @(negedge clk);
    if (hold > 0) begin
      cmd_valid = 1'b1; cmd_key = 16'h2222; cmd_bucket = 2'd0; cmd_head_vld = 1'b0;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R8 cmd_ready during hold", int'(cmd_ready), 0);
        chk(res_valid && res_code == 2'(ecode), "R8 result held", int'(res_code), ecode);
      end
      cmd_valid = 1'b0; res_ready = 1'b1;
    end
    chk(int'(res_code) == ecode, "R2/R4/R6 result code", int'(res_code), ecode);
    chk(int'(res_key) == key, "R1 result key", int'(res_key), key);
    @(negedge clk);
    if (ecode == 0) begin
      chk(tk == 1, "R7 one take per new cell", tk, 1);
      if (was_empty) begin
        chk(hw_cnt == 1 && wn == 1, "R2 head+cell writes", hw_cnt * 10 + wn, 11);
        chk(hw_cyc < rw_cyc && wl_nv[0] == 0, "R2 head before cell", rw_cyc - hw_cyc, 1);
      end else begin
        chk(hw_cnt == 0 && wn == 2, "R5 two cell writes", hw_cnt * 10 + wn, 2);
        chk(wl_nv[0] == 0 && wl_nv[1] == 1 && wl_next[1] == wl_addr[0],
            "R5 new cell then link", wl_next[1], wl_addr[0]);
      end
      mk[b].push_back(key); ncnt++; n_added++;
    end else if (ecode == 1) begin
      chk(tk == 0 && wn == 1 && hw_cnt == 0, "R4 single update, no take", tk * 100 + wn * 10 + hw_cnt, 10);
      chk(wl_addr[0] >= 0, "R4 update logged", wn, 1);
    end else begin
      chk(tk == 0 && wn == 0 && hw_cnt == 0, "R6 full leaves table", tk * 100 + wn * 10 + hw_cnt, 0);
    end
    if (ecode != 2) mval[key] = val;
    // R3: walk the bench RAM and compare with the model list
    if (mk[b].size() > 0) chk(hv[b] == 1'b1, "R3 head valid", int'(hv[b]), 1);
    p = int'(hptr[b]);
    foreach (mk[b][i]) begin
      chk(int'(m_key[p]) == mk[b][i], "R3 chain key order", int'(m_key[p]), mk[b][i]);
      chk(int'(m_val[p]) == (mval[mk[b][i]] & 8'hFF), "R3 chain value", int'(m_val[p]), mval[mk[b][i]]);
      if (i == mk[b].size() - 1) chk(m_nv[p] == 1'b0, "R3 tail terminated", int'(m_nv[p]), 0);
      p = int'(m_next[p]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", int'(cmd_ready), 1);
    chk(res_valid == 1'b0 && ram_wr_en == 1'b0 && head_wr_en == 1'b0 && alloc_take == 1'b0,
        "R1 reset outputs idle", int'(res_valid), 0);
    run_cmd(32'h4000, 8'h11, 0);  // empty bucket
    run_cmd(32'h4001, 8'h12, 0);  // tail append
    run_cmd(32'h4000, 8'h13, 0);  // same key at head
    run_cmd(32'h4002, 8'h14, 0);
    run_cmd(32'h4001, 8'h15, 0);  // same key mid-list
    run_cmd(32'h8000, 8'h16, 0);  // second bucket
    run_cmd(32'h4003, 8'h17, 0);
    run_cmd(32'h4004, 8'h18, 0);
    run_cmd(32'h4005, 8'h19, 0);
    run_cmd(32'h4006, 8'h1A, 0);
    chk(n_added == N, "R9 all cells filled", n_added, N);
    run_cmd(32'h4007, 8'h1B, 0);  // full on long list
    run_cmd(32'hC000, 8'h1C, 0);  // full on empty bucket
    run_cmd(32'h4006, 8'h1D, 4);  // same key while full, with back-pressure
    run_cmd(32'h4000, 8'h1E, 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule